// File: doc/BRIEF.md
# Step Voltage Regulator Tap Controller

This block is the digital control loop for a step-type voltage regulator. The regulator adds a voltage to the mains, or takes one from it, through three series transformers with binary weights. The block accepts signed load-voltage samples on a strobe. It forms an RMS value over a fixed window of samples, nominally one half cycle of the mains. It compares that value with a programmable reference, ignores deviations inside a programmable tolerance band, and converts larger deviations into a whole number of voltage steps. Those steps are integrated in a saturating signed accumulator.

The accumulator magnitude selects which series stages are inserted: a bit of 1 inserts the stage and a bit of 0 shorts its primary. The accumulator sign selects the injection polarity. The outputs change once per window, on a single-cycle update strobe. Each phase of a three-phase system uses its own instance.

Top module: `tapreg_top`

## Requirements
- R1: After reset the accumulator is 0, `ins_o` is 3'b000, `pol_add_o` is 1, `upd_o` is 0 and `rms_o` is 0.
- R2: Every WIN (default 83) accepted samples, `rms_o` is loaded with floor(sqrt(floor(S/WIN))), where S is the sum of the squared samples in that window. One `upd_o` pulse follows, and `rms_o` already holds the new value during that pulse.
- R3: A cycle with `smp_valid_i` low contributes nothing to any window, whatever `smp_data_i` carries.
- R4: Let d = |ref - rms|. When d * 2^FRAC_W <= tol * ref, the step is 0 and the accumulator does not change (tol is `tol_i`, a fraction scaled by 2^FRAC_W).
- R5: Outside the band, the step is (ref - rms) * 2^FRAC_W / (ref * p), rounded to the nearest integer with ties away from zero. Here p is `step_sz_i`, a fraction scaled by 2^FRAC_W. A positive step means a sag. If ref or p is 0, the step is 0.
- R6: On each update the step is added to the accumulator, and the result is clamped to the range -7..+7.
- R7: `ins_o` is the 3-bit binary magnitude of the accumulator. `ins_o[2]` drives the largest stage (weight 4) and `ins_o[0]` the smallest (weight 1).
- R8: `pol_add_o` is 1 (additive injection) when the accumulator is positive and 0 (subtractive injection) when it is negative. It keeps its previous value when the accumulator is 0.
- R9: `ins_o` and `pol_add_o` change only on the edge that raises `upd_o`, and `upd_o` is high for exactly one cycle per window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid_i | input | 1 | Sample strobe (nominally 10 kHz) |
| smp_data_i | input | SMP_W | Signed load-voltage sample |
| ref_rms_i | input | SMP_W | Target RMS, same scale as `rms_o` |
| tol_i | input | FRAC_W | Deadband as a fraction times 2^FRAC_W |
| step_sz_i | input | FRAC_W | Per-unit smallest stage voltage times 2^FRAC_W |
| ins_o | output | 3 | Stage insertion bits, bit 2 = largest stage |
| pol_add_o | output | 1 | 1 additive, 0 subtractive |
| upd_o | output | 1 | One-cycle pulse after each update |
| rms_o | output | SMP_W | Last computed window RMS |

## Verification
The assertions assume three things about the inputs. First, `ref_rms_i`, `tol_i` and `step_sz_i` are steady from the end of a window until its update has been applied. Second, sample strobes are spaced so that no window completes within two cycles of another. Third, the reset is held from time zero. The bench changes the setpoints only at the start of a window and always leaves idle cycles between samples, which keeps the stimulus inside all three assumptions. The idle cycles carry random garbage data to exercise R3. Directed windows of alternating ±A samples give exact RMS values. These windows hit the deadband edge, the half-step ties in both signs, saturation at both ends and a return to zero with the polarity held. Random windows then vary the amplitude, the reference, the tolerance and the step size.

// File: rtl/tapreg_pkg.sv
package tapreg_pkg;
  localparam int ACC_W   = 4;
  localparam int ACC_MAX = 7;
  localparam int STEP_W  = 6;
  localparam int STEP_LIM = 15;

  typedef logic signed [ACC_W-1:0]  acc_t;
  typedef logic signed [STEP_W-1:0] step_t;

  // floor square root, one result bit per iteration
  function automatic logic [31:0] isqrt64(input logic [63:0] v);
    logic [31:0] r;
    logic [31:0] c;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      c = r | (32'd1 << i);
      if (({32'd0, c} * {32'd0, c}) <= v) r = c;
    end
    return r;
  endfunction

  // deviation inside the tolerance band
  function automatic logic in_band(input logic [63:0] diff, input logic [63:0] refv,
                                   input logic [63:0] tol, input int fb);
    return (diff << fb) <= (tol * refv);
  endfunction

  // round-half-away-from-zero of diff*2^fb/den, signed, limited to +-STEP_LIM
  function automatic step_t round_steps(input logic [63:0] diff, input logic neg,
                                        input logic [63:0] den, input int fb);
    logic [63:0] q;
    step_t s;
    if (den == 64'd0) return '0;
    q = ((diff << (fb + 1)) + den) / (den << 1);
    if (q > 64'(STEP_LIM)) q = 64'(STEP_LIM);
    s = step_t'(q[STEP_W-1:0]);
    return neg ? -s : s;
  endfunction

  function automatic acc_t sat_add(input acc_t a, input step_t s);
    logic signed [STEP_W:0] t;
    t = {{(STEP_W + 1 - ACC_W){a[ACC_W-1]}}, a} + {s[STEP_W-1], s};
    if (t > (STEP_W + 1)'(ACC_MAX)) return acc_t'(ACC_MAX);
    if (t < -(STEP_W + 1)'(ACC_MAX)) return -acc_t'(ACC_MAX);
    return t[ACC_W-1:0];
  endfunction

  function automatic logic [2:0] mag3(input acc_t a);
    acc_t m;
    m = a[ACC_W-1] ? -a : a;
    return m[2:0];
  endfunction
endpackage

// File: rtl/tapreg_rms.sv
module tapreg_rms #(
  parameter int SMP_W = 12,
  parameter int WIN   = 83
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid_i,
  input  logic signed [SMP_W-1:0] smp_data_i,
  output logic [SMP_W-1:0]        rms_o,
  output logic                    rms_vld_o
);
  import tapreg_pkg::*;
  localparam int SQ_W  = 2 * SMP_W;
  localparam int CNT_W = $clog2(WIN + 1);
  localparam int SUM_W = SQ_W + CNT_W;

  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] sum_q;
  logic [SQ_W-1:0]  mean_q;
  logic             mean_vld_q;
  logic [SMP_W-1:0] mag;
  logic [SQ_W-1:0]  sq;
  logic [SUM_W-1:0] sum_n;
  logic             win_last;

  assign mag      = smp_data_i[SMP_W-1] ? SMP_W'(-smp_data_i) : SMP_W'(smp_data_i);
  assign sq       = SQ_W'(mag) * SQ_W'(mag);
  assign sum_n    = sum_q + SUM_W'(sq);
  assign win_last = smp_valid_i && (cnt_q == CNT_W'(WIN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      sum_q      <= '0;
      mean_q     <= '0;
      mean_vld_q <= 1'b0;
    end else begin
      mean_vld_q <= win_last;
      if (win_last) begin
        cnt_q  <= '0;
        sum_q  <= '0;
        mean_q <= SQ_W'(sum_n / SUM_W'(WIN));
      end else if (smp_valid_i) begin
        cnt_q <= cnt_q + 1'b1;
        sum_q <= sum_n;
      end
    end
  end

  logic [31:0] root;
  assign root = isqrt64(64'(mean_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rms_o     <= '0;
      rms_vld_o <= 1'b0;
    end else begin
      rms_vld_o <= mean_vld_q;
      if (mean_vld_q) rms_o <= root[SMP_W-1:0];
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt_q < CNT_W'(WIN)) else $error("cnt range"); // R2
  AST_ROOT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) mean_vld_q |=> rms_vld_o) else $error("rms late"); // R2
  AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) !smp_valid_i |=> ($stable(cnt_q) && $stable(sum_q))) else $error("idle used"); // R3
endmodule

// File: rtl/tapreg_quant.sv
module tapreg_quant #(
  parameter int SMP_W  = 12,
  parameter int FRAC_W = 8
) (
  input  logic [SMP_W-1:0]        rms_i,
  input  logic [SMP_W-1:0]        ref_i,
  input  logic [FRAC_W-1:0]       tol_i,
  input  logic [FRAC_W-1:0]       step_sz_i,
  output tapreg_pkg::step_t       step_o,
  output logic                    band_o
);
  import tapreg_pkg::*;
  logic        sw_up;
  logic [63:0] diff;
  logic [63:0] den;

  assign sw_up  = rms_i > ref_i;
  assign diff   = sw_up ? 64'(rms_i - ref_i) : 64'(ref_i - rms_i);
  assign den    = 64'(ref_i) * 64'(step_sz_i);
  assign band_o = in_band(diff, 64'(ref_i), 64'(tol_i), FRAC_W);
  assign step_o = band_o ? '0 : round_steps(diff, sw_up, den, FRAC_W);
endmodule

// File: rtl/tapreg_integ.sv
module tapreg_integ (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply_i,
  input  tapreg_pkg::step_t step_i,
  output logic [2:0]        ins_o,
  output logic              pol_add_o,
  output logic              upd_o
);
  import tapreg_pkg::*;
  acc_t acc_q;
  acc_t acc_n;

  assign acc_n = sat_add(acc_q, step_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      ins_o     <= 3'b000;
      pol_add_o <= 1'b1;
      upd_o     <= 1'b0;
    end else begin
      upd_o <= apply_i;
      if (apply_i) begin
        acc_q <= acc_n;
        ins_o <= mag3(acc_n);
        if (acc_n > 0)      pol_add_o <= 1'b1;
        else if (acc_n < 0) pol_add_o <= 1'b0;
      end
    end
  end

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n) !apply_i |=> ($stable(ins_o) && $stable(pol_add_o))) else $error("output moved"); // R9
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) upd_o |=> !upd_o) else $error("long pulse"); // R9
  AST_ZERO_STEP: assert property (@(posedge clk) disable iff (!rst_n) (apply_i && step_i == '0) |=> $stable(acc_q)) else $error("acc moved"); // R4
  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n) (apply_i && acc_q == 4'sd7 && step_i > 0) |=> acc_q == 4'sd7) else $error("top sat"); // R6
  AST_SAT_BOT: assert property (@(posedge clk) disable iff (!rst_n) (apply_i && acc_q == -4'sd7 && step_i < 0) |=> acc_q == -4'sd7) else $error("bottom sat"); // R6
  AST_POL_SIGN: assert property (@(posedge clk) disable iff (!rst_n) (acc_q != '0) |-> (pol_add_o == (acc_q > 0))) else $error("polarity"); // R8
  AST_ZERO_POL: assert property (@(posedge clk) disable iff (!rst_n) (apply_i && acc_n == '0) |=> $stable(pol_add_o)) else $error("pol toggled"); // R8
endmodule

// File: rtl/tapreg_top.sv
module tapreg_top #(
  parameter int SMP_W  = 12,
  parameter int WIN    = 83,
  parameter int FRAC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid_i,
  input  logic signed [SMP_W-1:0] smp_data_i,
  input  logic [SMP_W-1:0]        ref_rms_i,
  input  logic [FRAC_W-1:0]       tol_i,
  input  logic [FRAC_W-1:0]       step_sz_i,
  output logic [2:0]              ins_o,
  output logic                    pol_add_o,
  output logic                    upd_o,
  output logic [SMP_W-1:0]        rms_o
);
  import tapreg_pkg::*;
  logic  rms_vld;
  step_t step;
  logic  band;

  tapreg_rms #(.SMP_W(SMP_W), .WIN(WIN)) u_rms (
    .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
    .rms_o(rms_o), .rms_vld_o(rms_vld)
  );

  tapreg_quant #(.SMP_W(SMP_W), .FRAC_W(FRAC_W)) u_quant (
    .rms_i(rms_o), .ref_i(ref_rms_i), .tol_i(tol_i), .step_sz_i(step_sz_i),
    .step_o(step), .band_o(band)
  );

  tapreg_integ u_integ (
    .clk(clk), .rst_n(rst_n), .apply_i(rms_vld), .step_i(step),
    .ins_o(ins_o), .pol_add_o(pol_add_o), .upd_o(upd_o)
  );

  AST_BAND_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n) (rms_vld && band) |=> ($stable(ins_o) && $stable(pol_add_o))) else $error("band moved outputs"); // R4
endmodule

// File: tb/sim_tapreg_top.sv
module sim_tapreg_top;
  localparam int SW = 12;
  localparam int WIN = 83;
  localparam int FB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [SW-1:0] smp_data = '0;
  logic [SW-1:0] ref_rms = '0;
  logic [FB-1:0] tol = '0;
  logic [FB-1:0] stp = '0;
  logic [2:0] ins;
  logic pol, upd;
  logic [SW-1:0] rms;

  int n_tests = 0, n_fail = 0, cycles = 0;
  int m_acc = 0;
  int m_pol = 1;
  bit finished = 0;
  int win_smp[WIN];

  always #10 clk = ~clk;

  tapreg_top u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .ref_rms_i(ref_rms), .tol_i(tol), .step_sz_i(stp),
    .ins_o(ins), .pol_add_o(pol), .upd_o(upd), .rms_o(rms)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_rms();
    longint s = 0;
    longint mean;
    longint r;
    for (int i = 0; i < WIN; i++) s += longint'(win_smp[i]) * longint'(win_smp[i]);
    mean = s / WIN;
    r = longint'($floor($sqrt(real'(mean))));
    while (r * r > mean) r--;
    while ((r + 1) * (r + 1) <= mean) r++;
    return int'(r);
  endfunction

  function automatic int exp_step(input int r, input int rf, input int tl, input int p);
    longint d = rf - r;
    longint ad = (d < 0) ? -d : d;
    real x;
    longint k;
    if (ad * 256 <= longint'(tl) * rf) return 0;
    if (rf == 0 || p == 0) return 0;
    x = real'(ad) * 256.0 / (real'(rf) * real'(p));
    k = longint'($floor(x + 0.5));
    if (k > 15) k = 15;
    return (d < 0) ? -int'(k) : int'(k);
  endfunction

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      finish_up();
    end
  end

  // mode 0: alternating +-amp, mode 1: +-amp with random jitter
  task automatic run_window(input int amp, input int mode, input int rf, input int tl, input int p);
    int r, s, to;
    @(negedge clk);
    ref_rms = SW'(rf); tol = FB'(tl); stp = FB'(p);
    for (int i = 0; i < WIN; i++) begin
      int a = amp;
      if (mode == 1) a = amp + int'($urandom_range(0, 40)) - 20;
      if (a > 2047) a = 2047;
      if (a < 0) a = 0;
      win_smp[i] = (i % 2 == 0) ? a : -a;
      @(negedge clk);
      smp_valid = 1'b1; smp_data = SW'(win_smp[i]);
      @(negedge clk);
      smp_valid = 1'b0; smp_data = SW'($urandom);  // R3 garbage while idle
      if (i == 3) begin  // R9 outputs hold mid-window
        check("R9 hold ins", ins, (m_acc < 0) ? -m_acc : m_acc);
        check("R9 hold pol", pol, m_pol);
      end
      if ($urandom_range(0, 3) == 0) begin @(negedge clk); smp_data = SW'($urandom); end
    end
    r = exp_rms();
    s = exp_step(r, rf, tl, p);
    m_acc += s;
    if (m_acc > 7) m_acc = 7;
    if (m_acc < -7) m_acc = -7;
    if (m_acc > 0) m_pol = 1; else if (m_acc < 0) m_pol = 0;
    to = 0;
    while (upd !== 1'b1 && to < 50) begin @(negedge clk); to++; end
    check("R9 update strobe seen", upd, 1);
    check("R2 rms", rms, r);
    check("R7 ins magnitude", ins, (m_acc < 0) ? -m_acc : m_acc);
    check("R8 polarity", pol, m_pol);
    @(negedge clk);
    check("R9 one-cycle strobe", upd, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ins", ins, 0);
    check("R1 pol", pol, 1);
    check("R1 upd", upd, 0);
    check("R1 rms", rms, 0);
    rst_n = 1'b1;
    // directed: ref 1024, tol 26/256, p 16/256 -> one step = 64 counts
    run_window(1024, 0, 1024, 26, 16);  // R4 zero deviation
    run_window(920, 0, 1024, 26, 16);   // R4 band edge d=104
    run_window(919, 0, 1024, 26, 16);   // R5 d=105 -> 2, acc 2
    check("R5 after first step", ins, 2);
    run_window(864, 0, 1024, 26, 16);   // R5 tie 2.5 -> 3, acc 5
    check("R5 positive tie", ins, 5);
    run_window(700, 0, 1024, 26, 16);   // R6 +5 -> clamp 7
    check("R6 top clamp", ins, 7);
    run_window(700, 0, 1024, 26, 16);   // R6 stays 7
    run_window(1184, 0, 1024, 26, 16);  // R5 tie -2.5 -> -3, acc 4
    check("R5 negative tie", ins, 4);
    run_window(1184, 0, 1024, 26, 16);  // acc 1
    run_window(1184, 0, 1024, 26, 16);  // acc -2
    check("R8 subtractive", pol, 0);
    run_window(919, 0, 1024, 26, 16);   // +2 -> acc 0, polarity held
    check("R8 hold at zero ins", ins, 0);
    check("R8 hold at zero pol", pol, 0);
    run_window(1600, 0, 1024, 26, 16);  // R6 -9 -> clamp -7
    check("R6 bottom clamp", ins, 7);
    run_window(1600, 0, 1024, 26, 0);   // R5 p=0 -> no step
    run_window(500, 0, 0, 26, 16);      // R5 ref=0 -> no step
    check("R5 zero divisor", ins, 7);
    // random phase
    for (int w = 0; w < 40; w++) begin
      int rf = int'($urandom_range(400, 3000));
      int amp = rf + int'($urandom_range(0, 800)) - 400;
      run_window(amp, 1, rf, int'($urandom_range(0, 40)), int'($urandom_range(4, 64)));
    end
    finish_up();
  end

  initial begin
    process::self().srandom(32'd12345);
  end
endmodule